// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the serial front end and storage of a small three-wire memory: 64 words of 16 bits behind a select line, a serial clock, a serial data input and a tristatable serial data output. All pins are sampled in the system clock domain. A rising edge of the serial clock is found by comparing the pin with its value one system clock earlier. The command decoder waits for a start bit, then shifts in a 2-bit opcode and a 6-bit address, most significant bit first. A write also shifts in 16 data bits. A read shifts out a dummy zero followed by the addressed word.

Writes and erases start a self-timed program cycle. It lasts a fixed number of system clocks and runs to its end whatever the select line and the serial clock do. The word is committed to storage when the cycle is launched. The timer only models the busy window. During that window, and afterwards until the host clears it, the output pin doubles as a ready/busy flag. The flag appears each time select rises with the decoder idle. A start bit followed by select falling, once the cycle has ended, removes it.

The FSM has five states:
- IDLE waits for a start bit, and shows status when armed.
- CMD shifts the opcode and address.
- WDATA shifts the write data.
- READ drives the dummy bit and the data bits.
- DONE ignores the pins until select falls.

The transitions are:
- Start (IDLE to CMD): taken on a rising edge with DI high and no program cycle running.
- Decode (CMD to READ, WDATA or DONE): taken on the eighth command bit.
- Data complete (WDATA to DONE): taken on the sixteenth data bit.
- Read complete (READ to DONE): taken on the seventeenth edge.
- Deselect (any state to IDLE): taken whenever select is low.

Top module: `mw_serial_mem`

## Requirements
- R1: After reset, DO is not driven, programming is disabled and every word reads 16'hFFFF.
- R2: While CS is low the decoder is held in IDLE and DO is not driven. An instruction cut short by CS falling has no effect on storage.
- R3: In IDLE with CS high, rising SCK edges with DI at 0 leave the state unchanged, so leading zeros before the start bit are ignored.
- R4: An instruction is a start bit (1), a 2-bit opcode and a 6-bit address, all sampled on SCK rising edges, MSB first. The opcodes are 10 READ, 01 WRITE, 11 ERASE and 00 extended; the extended kind is chosen by address bits [5:4].
- R5: READ drives DO with a dummy 0 after the last address bit. Each of the next 16 rising edges then presents one data bit, MSB first. The 17th edge releases DO.
- R6: WRITE takes 16 data bits, MSB first, and stores them. ERASE sets the addressed word to 16'hFFFF.
- R7: Extended code 11 enables programming and code 00 disables it. While programming is disabled, WRITE, ERASE and both all-word codes leave storage unchanged.
- R8: Extended code 10 sets every word to 16'hFFFF. Extended code 01 takes 16 data bits and writes them to every word.
- R9: A program cycle stays busy for exactly PROG_CYCLES system clocks, regardless of CS and SCK. Start bits during a busy cycle are ignored.
- R10: After a program cycle is launched, any CS rise with the decoder idle drives DO with the status: 0 while busy, 1 when ready.
- R11: If CS stays low through the whole program cycle, DO stays undriven.
- R12: After the cycle ends, a start bit followed by CS falling clears the status, so the next CS rise leaves DO undriven.
- R13: Once an instruction's bit count is complete, further SCK and DI activity is ignored until CS falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Select, active high |
| sck_i | input | 1 | Serial clock pin |
| di_i | input | 1 | Serial data input |
| do_o | output | 1 | Serial data output value |
| do_oe_o | output | 1 | Output enable for DO; low means high-impedance |

## Verification
The assertions take these input conditions for granted:
- SCK and CS are quasi-static relative to the system clock.
- Each SCK level lasts at least one system clock, so every serial edge is seen exactly once.
- DI is stable at the system clock edge where a serial rising edge is detected.

The stimulus keeps to these conditions. It changes all pins on the falling system clock edge and holds each SCK level for two system clocks. It moves CS only while SCK is low. Random addresses, data and operation choices come from a fixed seed and are interleaved with directed sequences for aborts, busy windows and status clearing.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CMD   = 3'd1,
        S_WDATA = 3'd2,
        S_READ  = 3'd3,
        S_DONE  = 3'd4
    } mw_state_e;

    // opcode field, first two bits after the start bit
    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    // extended kind, top two address bits when the opcode is OP_EXT
    localparam logic [1:0] EXT_LOCK   = 2'b00;
    localparam logic [1:0] EXT_FILL   = 2'b01;
    localparam logic [1:0] EXT_CLRALL = 2'b10;
    localparam logic [1:0] EXT_UNLOCK = 2'b11;
endpackage

// File: rtl/mw_edge_det.sv
module mw_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic rise_o
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_i;
    end

    assign rise_o = sck_i & ~sck_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt    <= '0;
        end else if (start_i && !busy_o) begin
            busy_o <= 1'b1;
            cnt    <= CW'(CYCLES - 1);
        end else if (busy_o) begin
            if (cnt == '0) busy_o <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/mw_regfile.sv
module mw_regfile #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          we_all_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int WORDS = 1 << AW;
    logic [WORDS-1:0][DW-1:0] mem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem <= '1;
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (we_all_i || (we_i && waddr_i == AW'(i))) mem[i] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/mw_serial_mem.sv
module mw_serial_mem
    import mw_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int CMDW = AW + 2;
    localparam int MAXB = (DW > CMDW) ? DW : CMDW;
    localparam int CNTW = $clog2(MAXB + 1);

    mw_state_e       state, state_n;
    logic [CNTW-1:0] bitcnt;
    logic [CMDW-1:0] cmd_sr, cmd_full;
    logic [DW-1:0]   data_sr, data_full;
    logic [DW:0]     rd_sr;
    logic            wen, armed, cs_q, rise, busy;
    logic            cmd_last, data_last, read_last;
    logic            prog_go, prog_all;
    logic [1:0]      op_now, ext_now, op_held;
    logic [AW-1:0]   prog_addr;
    logic [DW-1:0]   prog_data, rdata;

    mw_edge_det u_edge (.clk(clk), .rst_n(rst_n), .sck_i(sck_i), .rise_o(rise));

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(prog_go), .busy_o(busy)
    );

    mw_regfile #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we_i(prog_go), .we_all_i(prog_go && prog_all),
        .waddr_i(prog_addr), .wdata_i(prog_data),
        .raddr_i(cmd_full[AW-1:0]), .rdata_o(rdata)
    );

    assign cmd_full  = {cmd_sr[CMDW-2:0], di_i};
    assign data_full = {data_sr[DW-2:0], di_i};
    assign op_now    = cmd_full[CMDW-1 -: 2];
    assign ext_now   = cmd_full[AW-1 -: 2];
    assign op_held   = cmd_sr[CMDW-1 -: 2];
    assign cmd_last  = cs_i && rise && state == S_CMD   && bitcnt == CNTW'(CMDW - 1);
    assign data_last = cs_i && rise && state == S_WDATA && bitcnt == CNTW'(DW - 1);
    assign read_last = cs_i && rise && state == S_READ  && bitcnt == CNTW'(DW);

    // program launch: erase kinds at end of command, write kinds at end of data
    always_comb begin
        prog_go   = 1'b0;
        prog_all  = 1'b0;
        prog_addr = cmd_full[AW-1:0];
        prog_data = '1;
        if (cmd_last && (op_now == OP_ERASE || (op_now == OP_EXT && ext_now == EXT_CLRALL))) begin
            prog_go  = wen;
            prog_all = (op_now == OP_EXT);
        end else if (data_last) begin
            prog_go   = wen;
            prog_all  = (op_held == OP_EXT);
            prog_addr = cmd_sr[AW-1:0];
            prog_data = data_full;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (!cs_i) begin
            state_n = S_IDLE;
        end else if (rise) begin
            unique case (state)
                S_IDLE:  if (di_i && !busy) state_n = S_CMD;
                S_CMD:   if (cmd_last) begin
                             if (op_now == OP_READ)
                                 state_n = S_READ;
                             else if (op_now == OP_WRITE || (op_now == OP_EXT && ext_now == EXT_FILL))
                                 state_n = S_WDATA;
                             else
                                 state_n = S_DONE;
                         end
                S_WDATA: if (data_last) state_n = S_DONE;
                S_READ:  if (read_last) state_n = S_DONE;
                S_DONE:  state_n = S_DONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // shift registers, bit counter, enable and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            cmd_sr  <= '0;
            data_sr <= '0;
            rd_sr   <= '0;
            wen     <= 1'b0;
            armed   <= 1'b0;
            cs_q    <= 1'b0;
        end else begin
            cs_q <= cs_i;
            if (prog_go) armed <= 1'b1;
            else if (cs_q && !cs_i && state != S_IDLE && !busy) armed <= 1'b0;

            if (!cs_i) begin
                bitcnt <= '0;
            end else if (rise) begin
                unique case (state)
                    S_IDLE:  bitcnt <= '0;
                    S_CMD: begin
                        cmd_sr <= cmd_full;
                        bitcnt <= cmd_last ? '0 : bitcnt + 1'b1;
                        if (cmd_last && op_now == OP_READ) rd_sr <= {1'b0, rdata};
                        if (cmd_last && op_now == OP_EXT && ext_now == EXT_UNLOCK) wen <= 1'b1;
                        if (cmd_last && op_now == OP_EXT && ext_now == EXT_LOCK)   wen <= 1'b0;
                    end
                    S_WDATA: begin
                        data_sr <= data_full;
                        bitcnt  <= bitcnt + 1'b1;
                    end
                    S_READ: begin
                        rd_sr  <= {rd_sr[DW-1:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    S_DONE:  bitcnt <= bitcnt;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        do_oe_o = 1'b0;
        do_o    = 1'b0;
        if (cs_i && state == S_READ) begin
            do_oe_o = 1'b1;
            do_o    = rd_sr[DW];
        end else if (cs_i && state == S_IDLE && armed) begin
            do_oe_o = 1'b1;
            do_o    = !busy;
        end
    end
endmodule

// File: rtl/mw_serial_mem_chk.sv
module mw_serial_mem_chk
    import mw_pkg::*;
#(
    parameter int PROG_CYCLES = 200
) (
    input logic      clk,
    input logic      rst_n,
    input logic      cs_i,
    input logic      di_i,
    input logic      do_o,
    input logic      do_oe_o,
    input mw_state_e state,
    input logic      busy,
    input logic      prog_go,
    input logic      wen
);
    int unsigned blen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    blen <= 0;
        else if (busy) blen <= blen + 1;
        else           blen <= 0;
    end

    // R2
    cs_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> state == S_IDLE);

    // R3
    no_start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !di_i) |=> state == S_IDLE);

    // R5
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ && cs_i) |-> do_oe_o);

    // R7
    locked_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> wen);

    // R9
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> blen == PROG_CYCLES);

    // R9
    busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state == S_IDLE) |=> state == S_IDLE);

    // R10
    status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe_o && state == S_IDLE) |-> do_o == !busy);
endmodule

bind mw_serial_mem mw_serial_mem_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .di_i(di_i), .do_o(do_o),
    .do_oe_o(do_oe_o), .state(state), .busy(busy), .prog_go(prog_go), .wen(wen)
);

// File: tb/mw_serial_mem_tb.sv
module mw_serial_mem_tb;
    localparam int PROG = 100;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, di = 1'b0;
    logic dout, dout_oe;
    int   n_chk = 0, n_fail = 0;
    bit   wen_m = 1'b0;
    logic [15:0] mdl [64];

    always #2 clk = ~clk;

    mw_serial_mem #(.AW(6), .DW(16), .PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di),
        .do_o(dout), .do_oe_o(dout_oe)
    );

    function automatic bit programs(logic [1:0] op, logic [1:0] ext);
        return wen_m && (op == 2'b01 || op == 2'b11 || (op == 2'b00 && (ext == 2'b10 || ext == 2'b01)));
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(bit b);
        di = b; sck = 1'b0; tick(2);
        sck = 1'b1; tick(2);
        sck = 1'b0;
    endtask

    task automatic cs_set(bit v);
        sck = 1'b0; cs = v; tick(2);
    endtask

    task automatic send(logic [1:0] op, logic [5:0] a);
        pulse(1'b1); pulse(op[1]); pulse(op[0]);
        for (int i = 5; i >= 0; i--) pulse(a[i]);
    endtask

    task automatic send_data(logic [15:0] d);
        for (int i = 15; i >= 0; i--) pulse(d[i]);
    endtask

    task automatic do_prog(logic [1:0] op, logic [5:0] a, logic [15:0] d);
        cs_set(1'b1);
        send(op, a);
        if (op == 2'b01 || (op == 2'b00 && a[5:4] == 2'b01)) send_data(d);
        cs_set(1'b0);
        if (programs(op, a[5:4])) begin
            if (op == 2'b01) mdl[a] = d;
            else if (op == 2'b11) mdl[a] = 16'hFFFF;
            else if (a[5:4] == 2'b10) for (int k = 0; k < 64; k++) mdl[k] = 16'hFFFF;
            else for (int k = 0; k < 64; k++) mdl[k] = d;
        end
        if (op == 2'b00 && a[5:4] == 2'b11) wen_m = 1'b1;
        if (op == 2'b00 && a[5:4] == 2'b00) wen_m = 1'b0;
        tick(PROG + 5);
    endtask

    task automatic do_read(logic [5:0] a, int nz, string tag);
        logic [15:0] got;
        cs_set(1'b1);
        repeat (nz) pulse(1'b0);
        send(2'b10, a);
        check({tag, " R5 dummy oe"}, dout_oe, 1);
        check({tag, " R5 dummy bit"}, dout, 0);
        for (int i = 15; i >= 0; i--) begin
            pulse(1'b0);
            got[i] = dout;
        end
        check({tag, " R4 data"}, got, mdl[a]);
        pulse(1'b0);
        check({tag, " R5 release"}, dout_oe, 0);
        cs_set(1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 64; k++) mdl[k] = 16'hFFFF;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check("R1 oe after reset", dout_oe, 0);
        do_read(6'd5, 0, "R1");

        // locked: write ignored
        do_prog(2'b01, 6'd5, 16'h1234);
        do_read(6'd5, 0, "R7 locked write");

        do_prog(2'b00, 6'b110000, 16'h0);
        do_prog(2'b01, 6'd5, 16'hA55A);
        do_read(6'd5, 7, "R3 R6 leading zeros");

        // R2: abort a write halfway
        cs_set(1'b1);
        send(2'b01, 6'd5);
        for (int i = 0; i < 8; i++) pulse(1'b1);
        cs_set(1'b0);
        check("R2 oe with cs low", dout_oe, 0);
        tick(PROG + 5);
        do_read(6'd5, 0, "R2 aborted write");

        do_prog(2'b11, 6'd5, 16'h0);
        do_read(6'd5, 0, "R6 erase");

        // R10 / R9 / R12: status on DO
        cs_set(1'b1);
        send(2'b01, 6'd9);
        send_data(16'h0F0F);
        mdl[9] = 16'h0F0F;
        cs_set(1'b0);
        cs_set(1'b1);
        check("R10 status oe busy", dout_oe, 1);
        check("R10 status busy value", dout, 0);
        send(2'b10, 6'd9);
        check("R9 start ignored while busy oe", dout_oe, 1);
        check("R9 start ignored while busy value", dout, 0);
        tick(PROG);
        check("R10 status ready value", dout, 1);
        pulse(1'b1);
        check("R12 status hidden after start bit", dout_oe, 0);
        cs_set(1'b0);
        cs_set(1'b1);
        check("R12 status cleared", dout_oe, 0);
        cs_set(1'b0);
        do_read(6'd9, 0, "R9 data after busy");

        // R11: CS low for the whole program cycle
        cs_set(1'b1);
        send(2'b01, 6'd10);
        send_data(16'hBEEF);
        mdl[10] = 16'hBEEF;
        cs_set(1'b0);
        tick(PROG / 2);
        check("R11 oe mid cycle", dout_oe, 0);
        tick(PROG);
        check("R11 oe after cycle", dout_oe, 0);
        do_read(6'd10, 0, "R11");

        // R8: clear all and fill all
        do_prog(2'b00, 6'b100000, 16'h0);
        do_read(6'd9, 0, "R8 clear all");
        do_prog(2'b00, 6'b010000, 16'h3C3C);
        do_read(6'd0, 0, "R8 fill low");
        do_read(6'd63, 0, "R8 fill high");

        // R13: second instruction under the same CS is ignored
        cs_set(1'b1);
        send(2'b01, 6'd1);
        send_data(16'h1111);
        send(2'b01, 6'd2);
        send_data(16'h2222);
        cs_set(1'b0);
        mdl[1] = 16'h1111;
        tick(PROG + 5);
        do_read(6'd2, 0, "R13 trailing write ignored");
        do_read(6'd1, 0, "R13 first write");

        // R7: lock again
        do_prog(2'b00, 6'b000000, 16'h0);
        do_prog(2'b01, 6'd3, 16'h0000);
        do_prog(2'b00, 6'b100000, 16'h0);
        do_read(6'd3, 0, "R7 relocked");

        // random mix
        do_prog(2'b00, 6'b110000, 16'h0);
        for (int it = 0; it < 30; it++) begin
            logic [5:0]  a;
            logic [15:0] d;
            int          sel;
            a   = 6'($urandom % 64);
            d   = 16'($urandom);
            sel = int'($urandom % 3);
            if (sel == 0)      do_prog(2'b01, a, d);
            else if (sel == 1) do_prog(2'b11, a, d);
            do_read(a, int'($urandom % 3), "R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule